// File: doc/BRIEF.md
# Keypad Priority Encoder with Strobe Front End

This block turns a bank of ten active-low decimal key lines into a 4-bit BCD code. The code is driven on active-low outputs. Lines for digits 1 to 9 take part in encoding. When several lines are asserted together, the highest-numbered one decides the code. Digit 0 encodes to BCD 0000, which is also the idle code, so its line plays no part in the code. It does count toward a separate key-down flag. That flag lets downstream logic tell "digit 0 pressed" apart from "no key".

A registered front end samples the true BCD value and the key-down flag on every clock. It waits until the pressed code has held unchanged for `STABLE_CYCLES` consecutive samples. It then raises a single-cycle strobe and latches the code onto a true-polarity output. Once a key has been reported, no further strobe can appear until every line has been seen released. Scanning a key matrix and filtering contact bounce are not part of this block.

Top module: `keypad_encoder`

## Requirements
- R1: `code_n` is the bitwise complement of the BCD value of the active digit. For example, only `key_n[3]` low gives `code_n = 4'b1100`, and only `key_n[1]` low gives `4'b1110`.
- R2: When several of `key_n[9:1]` are low, the highest-numbered low line sets `code_n`. For example, `key_n[9]` low always gives `code_n = 4'b0110`.
- R3: With all ten lines high, `code_n = 4'b1111` and `key_down = 0`.
- R4: With only `key_n[0]` low, `code_n = 4'b1111` and `key_down = 1`.
- R5: `key_down` is 1 exactly when at least one of `key_n[9:0]` is low. It is combinational.
- R6: Suppose `key_n` changes to a pressed pattern just before a rising edge and then holds. `strobe` is low after the first `STABLE_CYCLES` rising edges, counting that edge. It is high after the next edge, and at that point `key_code` carries the true BCD value of the highest active digit.
- R7: `strobe` is never high in two consecutive cycles.
- R8: After a strobe, no further strobe occurs until `key_down` has been low at a rising edge, even if the pressed code changes meanwhile.
- R9: A change of the pressed code before its strobe restarts the stability count, with the same timing as R6 measured from the change.
- R10: While `rst_n` is low, `strobe = 0` and `key_code = 4'b0000`.
- R11: `key_code` changes only in a cycle in which `strobe` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the front end |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_n | input | 10 | Active-low digit lines, bit i is digit i |
| code_n | output | 4 | Active-low BCD of the highest active digit (combinational) |
| key_down | output | 1 | High while any digit line is low (combinational) |
| strobe | output | 1 | One-cycle pulse when a new stable key is accepted |
| key_code | output | 4 | True-polarity BCD of the last accepted key |

## Verification
The clocked checks assume that `key_n` is steady around each rising edge. They also assume it changes only between edges, as it would after a synchroniser. The bench therefore drives every input change on the falling edge. The release-lockout check takes `key_down` sampled at rising edges as the reference for a release, so the stimulus holds released states for several whole cycles before pressing again.

// File: rtl/keypad_enc_pkg.sv
package keypad_enc_pkg;
    localparam int unsigned DIGITS = 10;
    localparam int unsigned BCD_W  = $clog2(DIGITS);
    typedef logic [BCD_W-1:0] bcd_t;
endpackage

// File: rtl/dec_prio_enc.sv
module dec_prio_enc #(
    parameter int unsigned DIGITS = 10,
    localparam int unsigned W     = $clog2(DIGITS)
) (
    input  logic [DIGITS-1:1] digit_n,
    output logic [W-1:0]      code_n
);
    logic [W-1:0] code;

    // ascending scan: a later (higher) active digit overrides
    always_comb begin
        code = '0;
        for (int i = 1; i < int'(DIGITS); i++) begin
            if (!digit_n[i]) code = W'(i);
        end
        code_n = ~code;
    end
endmodule

// File: rtl/key_any_detect.sv
module key_any_detect #(
    parameter int unsigned DIGITS = 10
) (
    input  logic [DIGITS-1:0] keys_n,
    output logic              pressed
);
    logic [DIGITS-1:0] act;

    genvar g;
    generate
        for (g = 0; g < int'(DIGITS); g++) begin : g_pol
            assign act[g] = ~keys_n[g];
        end
    endgenerate

    assign pressed = |act;
endmodule

// File: rtl/key_stab_ctrl.sv
module key_stab_ctrl #(
    parameter int unsigned STABLE_CYCLES = 4,
    parameter int unsigned CODE_W        = 4,
    localparam int unsigned CNT_W        = $clog2(STABLE_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code_in,
    input  logic              down_in,
    output logic              strobe,
    output logic [CODE_W-1:0] key_code
);
    typedef struct packed {
        logic [CODE_W-1:0] code_s;
        logic              down_s;
        logic [CODE_W-1:0] held;
        logic              held_down;
        logic [CNT_W-1:0]  cnt;
        logic              armed;
        logic              valid;
        logic [CODE_W-1:0] key_code;
    } state_t;

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(STABLE_CYCLES);

    state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.code_s    = code_in;
        st_d.down_s    = down_in;
        st_d.held      = st_q.code_s;
        st_d.held_down = st_q.down_s;
        st_d.valid     = 1'b0;

        if (!st_q.down_s) begin
            st_d.cnt   = '0;
            st_d.armed = 1'b1;
        end else if (!st_q.held_down || st_q.code_s != st_q.held) begin
            st_d.cnt = CNT_W'(1);
        end else if (st_q.cnt != CNT_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end

        if (st_q.down_s && st_q.armed && st_d.cnt == CNT_MAX) begin
            st_d.valid    = 1'b1;
            st_d.armed    = 1'b0;
            st_d.key_code = st_q.code_s;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.armed <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign strobe   = st_q.valid;
    assign key_code = st_q.key_code;
endmodule

// File: rtl/keypad_encoder.sv
module keypad_encoder
    import keypad_enc_pkg::*;
#(
    parameter int unsigned STABLE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIGITS-1:0] key_n,
    output logic [BCD_W-1:0]  code_n,
    output logic              key_down,
    output logic              strobe,
    output logic [BCD_W-1:0]  key_code
);
    bcd_t code_true;

    dec_prio_enc #(.DIGITS(DIGITS)) i_enc (
        .digit_n (key_n[DIGITS-1:1]),
        .code_n  (code_n)
    );

    key_any_detect #(.DIGITS(DIGITS)) i_any (
        .keys_n  (key_n),
        .pressed (key_down)
    );

    assign code_true = ~code_n;

    key_stab_ctrl #(.STABLE_CYCLES(STABLE_CYCLES), .CODE_W(BCD_W)) i_stab (
        .clk      (clk),
        .rst_n    (rst_n),
        .code_in  (code_true),
        .down_in  (key_down),
        .strobe   (strobe),
        .key_code (key_code)
    );
endmodule

// File: rtl/keypad_encoder_chk.sv
module keypad_encoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [9:0] key_n,
    input logic [3:0] code_n,
    input logic       key_down,
    input logic       strobe,
    input logic [3:0] key_code
);
    logic locked_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        locked_q <= 1'b0;
        else if (strobe)   locked_q <= 1'b1;
        else if (!key_down) locked_q <= 1'b0;
    end

    // R2
    top_digit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !key_n[9] |-> code_n == 4'b0110);

    // R3
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        &key_n |-> (code_n == 4'b1111 && !key_down));

    // R5
    any_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(&key_n) |-> key_down);

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe);

    // R8
    release_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !locked_q);

    // R11
    code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(key_code) |-> strobe);
endmodule

bind keypad_encoder keypad_encoder_chk i_chk (.*);

// File: tb/test_keypad_encoder.sv
module test_keypad_encoder;
    localparam int S = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] key_n = 10'h3FF;
    logic [3:0] code_n;
    logic       key_down;
    logic       strobe;
    logic [3:0] key_code;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    keypad_encoder #(.STABLE_CYCLES(S)) i_keypad_encoder (
        .clk(clk), .rst_n(rst_n), .key_n(key_n), .code_n(code_n),
        .key_down(key_down), .strobe(strobe), .key_code(key_code)
    );

    // {key_n, expected code_n, expected key_down}
    localparam logic [14:0] VEC [12] = '{
        {10'h3FF, 4'hF, 1'b1 ^ 1'b1},
        {10'h3F7, 4'hC, 1'b1},
        {10'h3FE, 4'hF, 1'b1},
        {10'h1FF, 4'h6, 1'b1},
        {10'h3FD, 4'hE, 1'b1},
        {10'h2FF, 4'h7, 1'b1},
        {10'h3DB, 4'hA, 1'b1},
        {10'h1FD, 4'h6, 1'b1},
        {10'h000, 4'h6, 1'b1},
        {10'h33E, 4'h8, 1'b1},
        {10'h3E7, 4'hB, 1'b1},
        {10'h3BF, 4'h9, 1'b1}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    // press at a falling edge, then check R6 timing and the captured code
    task automatic press_and_expect(input logic [9:0] k, input int bcd, input string tag);
        key_n = k;
        edges(S);
        chk({tag, " strobe low before window"}, int'(strobe), 0);
        edges(1);
        chk({tag, " strobe high"}, int'(strobe), 1);
        chk({tag, " key_code"}, int'(key_code), bcd);
        edges(1);
        chk("R7 strobe drops", int'(strobe), 0);
    endtask

    task automatic release_keys();
        key_n = 10'h3FF;
        edges(3);
    endtask

    initial begin
        #20000;
        $display("FAIL watchdog actual=running expected=finished");
        failures++;
        done = 1'b1;
    end

    initial begin
        // R10 reset state
        edges(2);
        chk("R10 strobe in reset", int'(strobe), 0);
        chk("R10 key_code in reset", int'(key_code), 0);
        rst_n = 1'b1;
        edges(2);
        chk("R10 strobe after reset", int'(strobe), 0);

        // R1 R2 R5 combinational table
        for (int i = 0; i < 12; i++) begin
            key_n = VEC[i][14:5];
            #1;
            chk("R1/R2 code_n", int'(code_n), int'(VEC[i][4:1]));
            chk("R5 key_down", int'(key_down), int'(VEC[i][0]));
        end
        release_keys();

        key_n = 10'h3FF; #1;
        chk("R3 idle code", int'(code_n), 4'hF);
        chk("R3 idle down", int'(key_down), 0);
        key_n = 10'h3FE; #1;
        chk("R4 zero code", int'(code_n), 4'hF);
        chk("R4 zero down", int'(key_down), 1);
        release_keys();

        // R6 fresh presses
        press_and_expect(10'h3F7, 3, "R6 digit3");
        release_keys();
        press_and_expect(10'h3FE, 0, "R6 digit0");
        release_keys();

        // R9 change before strobe restarts count
        key_n = 10'h3DF;
        edges(2);
        chk("R9 no early strobe", int'(strobe), 0);
        press_and_expect(10'h37F, 7, "R9 restart digit7");

        // R8 code change while held gives no strobe
        key_n = 10'h1FF;
        for (int i = 0; i < 3 * S; i++) begin
            edges(1);
            chk("R8 locked strobe", int'(strobe), 0);
        end
        chk("R11 key_code held", int'(key_code), 7);
        release_keys();
        press_and_expect(10'h1FF, 9, "R8 after release digit9");
        release_keys();

        done = 1'b1;
    end

    initial begin
        wait (done);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule